// File: doc/BRIEF.md
# Cartridge Wait-State Access Timer

This block times accesses on an external cartridge bus. It keeps a 16-bit wait-control register. For every access it works out how many stall cycles the bus needs, then raises a one-cycle ready strobe once that many cycles have passed. The count depends on four things: the region addressed, the access width, whether the access continues a sequential burst, and the fields of the control register. The region is either the save memory or one of three ROM windows, and each window can also be reached through a mirror. Region code 7 stands for memory with fixed zero-wait timing.

A bus master writes the control register whenever it likes and reads it back at any time. For each access it gives the region, the width and the sequential flag with a single-cycle start strobe, and it holds its bus cycle until ready comes. Bit 14 (prefetch enable) is kept and read back but does not change the timing.

Top module: `cart_wait_timer`

## Requirements
- R1: After reset the control register reads 0x0000 and ready is low.
- R2: A write stores all 16 bits of the written value, and reading returns them from the next cycle on. With no write the register keeps its value.
- R3: For a 16-bit nonsequential access to a ROM window, the wait count comes from that window's 2-bit first-access code. The codes 0, 1, 2 and 3 give 4, 3, 2 and 8 cycles. The codes sit at bits 3:2 for window 0, bits 6:5 for window 1 and bits 9:8 for window 2.
- R4: For a 16-bit sequential ROM access the wait count is 1 when the window's sequential bit is set. When the bit is clear the count is 2 for window 0, 4 for window 1 and 8 for window 2. The sequential bits are bit 4 for window 0, bit 7 for window 1 and bit 10 for window 2.
- R5: A 32-bit nonsequential ROM access waits the first-access count, plus 1, plus the sequential count.
- R6: A 32-bit sequential ROM access waits twice the sequential count plus 1.
- R7: Save memory (region 0) takes its wait from bits 1:0, using the same code-to-cycles mapping as R3, and ignores the sequential flag. A 32-bit save-memory access waits twice that count plus 1.
- R8: The region codes are: 0 save memory, 1 and 2 window 0, 3 and 4 window 1, 5 and 6 window 2. The two codes of each window give identical timing.
- R9: Region 7 has zero wait, so ready is high in the cycle right after the start edge.
- R10: If start is sampled at clock edge E with a count of N, ready is high for exactly the one cycle that follows edge E+N. It stays low during the cycles in between.
- R11: An access uses the register value that holds at its start edge. A write made in the same cycle as a start, or while an access is counting, applies only to later accesses.
- R12: A start that arrives while an access is still counting is ignored. It produces no extra ready and does not change the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 16 | Value to write into the control register |
| cfg_rdata | output | 16 | Current value of the control register |
| acc_start | input | 1 | One-cycle strobe that starts an access |
| acc_region | input | 3 | Region code of the access (R8) |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| acc_seq | input | 1 | 1 = sequential access |
| acc_ready | output | 1 | One-cycle strobe marking the end of the wait |

## Verification
A wrong lookup entry, or a register field read from the wrong bits, shows up as a ready pulse that comes early or late. The error is visible within at most 18 cycles of the start that uses that entry. A counter that reloads on a second start, or that forgets to go idle, shows up as an extra ready or a missing one. Every access is matched against a queue of expected counts, so any stray ready is caught in the cycle it appears. A register that latches writes at the wrong moment shows up on readback one cycle after the write, and in the count of the first access that follows.

// File: rtl/cwt_pkg.sv
// Shared constants and the first-access code mapping of the cartridge
// wait-state timer. Assumes a 16-bit control word with evenly spaced
// window fields.
package cwt_pkg;

    localparam int CFG_W        = 16;
    localparam int REGION_W     = 3;
    localparam int SRAM_LSB     = 0;
    localparam int FIELD_BASE   = 2;
    localparam int FIELD_STRIDE = 3;

    typedef enum logic [REGION_W-1:0] {
        RGN_SAVE   = 3'd0,
        RGN_W0     = 3'd1,
        RGN_W0_MIR = 3'd2,
        RGN_W1     = 3'd3,
        RGN_W1_MIR = 3'd4,
        RGN_W2     = 3'd5,
        RGN_W2_MIR = 3'd6,
        RGN_FIXED  = 3'd7
    } region_e;

    // Translate a 2-bit first-access code into wait cycles.
    function automatic int unsigned first_wait(input logic [1:0] code);
        case (code)
            2'd0:    return 4;
            2'd1:    return 3;
            2'd2:    return 2;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/cwt_window.sv
// Wait count for one ROM window. Assumes SLOW_SEQ is the window's
// sequential wait when its fast bit is clear. Purely combinational.
module cwt_window #(
    parameter int SLOW_SEQ = 2,
    parameter int CNT_W    = 5
) (
    input  logic [1:0]       first_code,
    input  logic             seq_fast,
    input  logic             wide,
    input  logic             seq,
    output logic [CNT_W-1:0] waits
);
    import cwt_pkg::*;

    logic [CNT_W-1:0] first_w;
    logic [CNT_W-1:0] seq_w;

    // Combine the halfword costs by access width and order.
    always_comb begin
        first_w = CNT_W'(first_wait(first_code));
        seq_w   = seq_fast ? CNT_W'(1) : CNT_W'(SLOW_SEQ);
        if (!wide)
            waits = seq ? seq_w : first_w;
        else if (seq)
            waits = (seq_w << 1) + CNT_W'(1);
        else
            waits = first_w + seq_w + CNT_W'(1);
    end

endmodule

// File: rtl/cwt_lookup.sv
// Picks the wait count for an access from the control word. Assumes the
// region coding of cwt_pkg: 0 save memory, pairs of codes per window,
// and any code above those has zero wait.
module cwt_lookup #(
    parameter int CFG_W   = 16,
    parameter int CNT_W   = 5,
    parameter int NUM_WIN = 3
) (
    input  logic [CFG_W-1:0]             cfg,
    input  logic [cwt_pkg::REGION_W-1:0] region,
    input  logic                         wide,
    input  logic                         seq,
    output logic [CNT_W-1:0]             waits
);
    import cwt_pkg::*;

    logic [CNT_W-1:0] win_waits [NUM_WIN];
    logic [CNT_W-1:0] save_w;

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            localparam int LSB = FIELD_BASE + FIELD_STRIDE * w;
            cwt_window #(
                .SLOW_SEQ (2 << w),
                .CNT_W    (CNT_W)
            ) i_win (
                .first_code (cfg[LSB +: 2]),
                .seq_fast   (cfg[LSB + 2]),
                .wide       (wide),
                .seq        (seq),
                .waits      (win_waits[w])
            );
        end
    endgenerate

    // Route the count of the addressed region to the output.
    always_comb begin
        save_w = CNT_W'(first_wait(cfg[SRAM_LSB +: 2]));
        waits  = '0;
        if (region == RGN_SAVE)
            waits = wide ? (save_w << 1) + CNT_W'(1) : save_w;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (region == REGION_W'(2 * i + 1) || region == REGION_W'(2 * i + 2))
                waits = win_waits[i];
        end
    end

endmodule

// File: rtl/cwt_counter.sv
// Stall counter. It loads a wait count on start and pulses ready once that
// many cycles have passed. Assumes len is valid in the cycle start is high.
// A start seen while counting is dropped.
module cwt_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             ready
);

    logic             active;
    logic [CNT_W-1:0] remain;

    // Load on an idle start, count down, and flag the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
            ready  <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (!active) begin
                if (start) begin
                    if (len == '0) begin
                        ready <= 1'b1;
                    end else begin
                        active <= 1'b1;
                        remain <= len;
                    end
                end
            end else begin
                if (remain == CNT_W'(1)) begin
                    active <= 1'b0;
                    ready  <= 1'b1;
                end
                remain <= remain - CNT_W'(1);
            end
        end
    end

    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active && len == '0) |=> ready);

    p_last_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && remain == CNT_W'(1)) |=> (ready && !active));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && remain > CNT_W'(1)) |=> (!ready && active));

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active) |=> (remain == $past(remain) - CNT_W'(1)));

endmodule

// File: rtl/cart_wait_timer.sv
// Cartridge wait-state access timer. It holds the wait-control register and
// times each access with a stall counter. Assumes a single outstanding
// access and a synchronous active-low reset.
module cart_wait_timer #(
    parameter int CFG_W   = 16,
    parameter int CNT_W   = 5,
    parameter int NUM_WIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             acc_start,
    input  logic [2:0]       acc_region,
    input  logic             acc_wide,
    input  logic             acc_seq,
    output logic             acc_ready
);

    logic [CFG_W-1:0] cfg_q;
    logic [CNT_W-1:0] len;

    // Hold the wait-control word; writes land at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= cfg_wdata;
    end

    assign cfg_rdata = cfg_q;

    cwt_lookup #(
        .CFG_W   (CFG_W),
        .CNT_W   (CNT_W),
        .NUM_WIN (NUM_WIN)
    ) i_lookup (
        .cfg    (cfg_q),
        .region (acc_region),
        .wide   (acc_wide),
        .seq    (acc_seq),
        .waits  (len)
    );

    cwt_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acc_start),
        .len   (len),
        .ready (acc_ready)
    );

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

endmodule

// File: tb/test_cart_wait_timer.sv
module test_cart_wait_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_start = 1'b0;
    logic [2:0]  acc_region = '0;
    logic        acc_wide = 1'b0;
    logic        acc_seq = 1'b0;
    logic        acc_ready;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int exp_q[$];
    int launch_q[$];
    int tag_q[$];
    logic [15:0] model_cfg = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cart_wait_timer i_cart_wait_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .acc_start  (acc_start),
        .acc_region (acc_region),
        .acc_wide   (acc_wide),
        .acc_seq    (acc_seq),
        .acc_ready  (acc_ready)
    );

    // Expected wait count, derived from R3 to R9.
    function automatic int exp_wait(logic [15:0] c, int region, bit wide, bit seq);
        int fmap[4] = '{4, 3, 2, 8};
        int w, f, s;
        if (region == 0) begin
            f = fmap[c[1:0]];
            return wide ? 2 * f + 1 : f;
        end
        if (region >= 1 && region <= 6) begin
            w = (region - 1) / 2;
            f = fmap[c[2 + 3 * w +: 2]];
            s = c[4 + 3 * w] ? 1 : (2 << w);
            if (!wide) return seq ? s : f;
            return seq ? 2 * s + 1 : f + 1 + s;
        end
        return 0;
    endfunction

    function automatic int req_of(int region, bit wide, bit seq);
        if (region == 7) return 9;
        if (region == 0) return 7;
        if (wide) return seq ? 6 : 5;
        return seq ? 4 : 3;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Driver: start one access, push its expected count (no wait for ready).
    task automatic fire(int region, bit wide, bit seq);
        @(negedge clk);
        acc_start  = 1'b1;
        acc_region = 3'(region);
        acc_wide   = wide;
        acc_seq    = seq;
        exp_q.push_back(exp_wait(model_cfg, region, wide, seq));
        launch_q.push_back(cyc);
        tag_q.push_back(req_of(region, wide, seq));
        @(negedge clk);
        acc_start = 1'b0;
    endtask

    task automatic run_access(int region, bit wide, bit seq);
        fire(region, wide, seq);
        wait (exp_q.size() == 0);
    endtask

    task automatic write_cfg(logic [15:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we     = 1'b0;
        model_cfg  = v;
        check(cfg_rdata == v, "R2 readback", int'(cfg_rdata), int'(v));
    endtask

    // Monitor: each ready pops one expected item; a stray ready fails R12.
    always @(negedge clk) begin
        if (rst_n && acc_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 stray ready", 1, 0);
            end else begin
                int e, l, t, got;
                e = exp_q.pop_front();
                l = launch_q.pop_front();
                t = tag_q.pop_front();
                got = cyc - l - 1;
                n_checks++;
                if (got != e) begin
                    n_errors++;
                    $display("FAIL R%0d/R10 wait actual=%0d expected=%0d", t, got, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R10 actual=hang expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 16'h0000, "R1 reset cfg", int'(cfg_rdata), 0);
        check(acc_ready == 1'b0, "R1 reset ready", int'(acc_ready), 0);

        write_cfg(16'hFFFF);
        write_cfg(16'h4A5C);
        @(negedge clk);
        check(cfg_rdata == 16'h4A5C, "R2 hold", int'(cfg_rdata), 16'h4A5C);

        // Sweep every region, width and order under three settings
        // (R3 R4 R5 R6 R7 R8 R9).
        for (int k = 0; k < 3; k++) begin
            logic [15:0] v;
            v = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0757 : 16'h42A6;
            write_cfg(v);
            for (int r = 0; r < 8; r++)
                for (int m = 0; m < 4; m++)
                    run_access(r, m[1], m[0]);
        end

        // R11: a write during a running access leaves that access alone.
        write_cfg(16'h0000);
        fire(5, 1'b1, 1'b1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'h0757;
        @(negedge clk);
        cfg_we = 1'b0;
        wait (exp_q.size() == 0);
        model_cfg = 16'h0757;
        run_access(5, 1'b1, 1'b1);

        // R11: a write in the same cycle as a start applies only afterwards.
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'h0000;
        acc_start = 1'b1; acc_region = 3'd5; acc_wide = 1'b1; acc_seq = 1'b1;
        exp_q.push_back(exp_wait(16'h0757, 5, 1'b1, 1'b1));
        launch_q.push_back(cyc);
        tag_q.push_back(11);
        @(negedge clk);
        cfg_we = 1'b0; acc_start = 1'b0;
        model_cfg = 16'h0000;
        wait (exp_q.size() == 0);
        run_access(5, 1'b1, 1'b1);

        // R12: a second start while counting is dropped.
        fire(5, 1'b1, 1'b1);
        @(negedge clk);
        acc_start = 1'b1; acc_region = 3'd7;
        @(negedge clk);
        acc_start = 1'b0;
        wait (exp_q.size() == 0);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R12 queue drained", exp_q.size(), 0);

        finish_run();
    end

endmodule